// File: doc/BRIEF.md
# SDRAM Precharge-to-Activate Guard

This block keeps the configuration word of a synchronous DRAM controller and makes sure that no bank-activate command leaves the controller too soon after a precharge. The command sequencer reports each event that starts a wait with a one-cycle strobe. The four events are an ordinary precharge, an all-bank precharge issued for auto-refresh, a single-bank precharge issued in bank-active mode, and an exit from self-refresh. The block then loads a down-counter with a length that depends on the event and on the 2-bit precharge code. While that counter is non-zero, `act_ok` is low, and the sequencer must hold back any activate command.

Software loads the configuration word through a simple write port. The other timing fields and the address-multiplex field of the word are passed out as plain outputs for the neighbouring logic. A power-on reset clears the word. A manual reset leaves the word as it is and only cancels a wait that is in progress.

Top module: `sdram_pre_act_guard`

## Requirements
- R1: While `por_n` is low and after it is released, `ctrl_q` reads 0x0000, `act_ok` is 1 and `cfg_err` is 0.
- R2: A write (`wr_en`=1) is visible on `ctrl_q` one cycle later as `wr_data` with bit 0 forced to 0. Bit 0 always reads 0.
- R3: A low level on `mrst_n` leaves `ctrl_q` unchanged and cancels any wait at once, so `act_ok` goes to 1.
- R4: An ordinary precharge strobe (`ev_pre`) holds `act_ok` low for 1, 2, 3 or 4 cycles for precharge code (`ctrl_q[15:14]`) 00, 01, 10 or 11. These cycles start with the cycle after the strobe.
- R5: An all-bank-for-refresh strobe (`ev_pall_ref`) or a bank-active precharge strobe (`ev_pre_bact`) gives a wait one cycle shorter: 0, 1, 2 or 3 cycles. A wait of 0 leaves `act_ok` high.
- R6: A self-refresh exit strobe (`ev_srex`) gives a wait of 2, 5, 8 or 11 cycles for codes 00 to 11.
- R7: When several strobes are high in one cycle, self-refresh exit wins. The shortened precharge comes next, and the ordinary precharge comes last.
- R8: A strobe that arrives during a running wait restarts the wait with the full length for the new event.
- R9: `cfg_err` is 1 exactly when bank-active mode (`ctrl_q[7]`) is 1 and the precharge code is 01.
- R10: The fields are passed out unchanged: `trcd_code`=bits 13:12, `twr_code`=11:10, `tras_code`=9:8, `bank_act_mode`=7, `amx_code`=6:3, `rfsh_en`=2, `rfsh_mode`=1.
- R11: If a write and a strobe occur in the same cycle, the wait length comes from the precharge code stored before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| mrst_n | input | 1 | Manual reset, asynchronous, active low; clears only the wait |
| wr_en | input | 1 | Configuration write strobe |
| wr_data | input | 16 | Configuration write data |
| ev_pre | input | 1 | Ordinary precharge issued |
| ev_pall_ref | input | 1 | All-bank precharge issued for auto-refresh |
| ev_pre_bact | input | 1 | Single-bank precharge issued in bank-active mode |
| ev_srex | input | 1 | Self-refresh exit |
| act_ok | output | 1 | High when a bank-activate may be issued |
| cfg_err | output | 1 | Forbidden code 01 with bank-active mode |
| ctrl_q | output | 16 | Stored configuration word |
| trcd_code | output | 2 | RAS-to-CAS code |
| twr_code | output | 2 | Write-recovery code |
| tras_code | output | 2 | RAS-active code |
| bank_act_mode | output | 1 | Bank-active mode enable |
| amx_code | output | 4 | Address-multiplex code |
| rfsh_en | output | 1 | Refresh enable |
| rfsh_mode | output | 1 | Refresh mode select |

## Verification
The clock edge that samples a strobe loads the counter. So `act_ok` is first low in the cycle after the strobe, and it stays low for exactly as many cycles as the wait length. The bench drives its inputs on falling edges and counts the falling edges at which `act_ok` is low until it rises again. That count is compared directly against the wait length. Register writes show on `ctrl_q` and `cfg_err` one edge after `wr_en`, and the effect of a manual reset on `act_ok` is sampled a moment after `mrst_n` falls, with no clock edge in between.

// File: rtl/sdram_guard_pkg.sv
package sdram_guard_pkg;

  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,
    EV_NORM  = 2'd1,
    EV_SHORT = 2'd2,
    EV_SREX  = 2'd3
  } pre_ev_e;

  // Wait length in cycles for a given event and precharge code.
  function automatic int unsigned wait_len(input pre_ev_e ev, input int unsigned code);
    case (ev)
      EV_NORM:  return code + 1;
      EV_SHORT: return code;
      EV_SREX:  return 3 * code + 2;
      default:  return 0;
    endcase
  endfunction

  function automatic int unsigned max_wait(input int unsigned code_w);
    return 3 * ((1 << code_w) - 1) + 2;
  endfunction

endpackage

// File: rtl/guard_cfg_reg.sv
module guard_cfg_reg #(
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] q
);
  // Only power-on reset clears the word; bit 0 is never stored.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)     q <= '0;
    else if (wr_en) q <= {wr_data[REG_W-1:1], 1'b0};
  end
endmodule

// File: rtl/guard_evt_sel.sv
module guard_evt_sel
  import sdram_guard_pkg::*;
#(
  parameter int CODE_W = 2,
  parameter int CNT_W  = 4
) (
  input  logic              ev_pre,
  input  logic              ev_pall_ref,
  input  logic              ev_pre_bact,
  input  logic              ev_srex,
  input  logic [CODE_W-1:0] code,
  output pre_ev_e           evt,
  output logic              load,
  output logic [CNT_W-1:0]  load_val
);
  always_comb begin
    if (ev_srex)                         evt = EV_SREX;
    else if (ev_pall_ref || ev_pre_bact) evt = EV_SHORT;
    else if (ev_pre)                     evt = EV_NORM;
    else                                 evt = EV_NONE;
  end

  assign load     = (evt != EV_NONE);
  assign load_val = CNT_W'(wait_len(evt, 32'(code)));
endmodule

// File: rtl/guard_wait_cnt.sv
module guard_wait_cnt #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             idle
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign idle = (cnt == '0);
endmodule

// File: rtl/sdram_pre_act_guard.sv
module sdram_pre_act_guard
  import sdram_guard_pkg::*;
#(
  parameter int REG_W  = 16,
  parameter int CODE_W = 2
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             mrst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             ev_pre,
  input  logic             ev_pall_ref,
  input  logic             ev_pre_bact,
  input  logic             ev_srex,
  output logic             act_ok,
  output logic             cfg_err,
  output logic [REG_W-1:0] ctrl_q,
  output logic [1:0]       trcd_code,
  output logic [1:0]       twr_code,
  output logic [1:0]       tras_code,
  output logic             bank_act_mode,
  output logic [3:0]       amx_code,
  output logic             rfsh_en,
  output logic             rfsh_mode
);
  localparam int MAX_WAIT = int'(max_wait(CODE_W));
  localparam int CNT_W    = $clog2(MAX_WAIT + 1);
  localparam int PC_LSB   = REG_W - CODE_W;

  logic [CODE_W-1:0] pc_code;
  logic              ld;
  logic [CNT_W-1:0]  ld_val;
  logic [CNT_W-1:0]  wait_cnt;
  logic              wait_idle;
  logic              cnt_rst_n;
  pre_ev_e           evt;

  guard_cfg_reg #(.REG_W(REG_W)) u_reg (
    .clk(clk), .por_n(por_n), .wr_en(wr_en), .wr_data(wr_data), .q(ctrl_q)
  );

  assign pc_code = ctrl_q[REG_W-1:PC_LSB];

  guard_evt_sel #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_sel (
    .ev_pre(ev_pre), .ev_pall_ref(ev_pall_ref), .ev_pre_bact(ev_pre_bact),
    .ev_srex(ev_srex), .code(pc_code), .evt(evt), .load(ld), .load_val(ld_val)
  );

  assign cnt_rst_n = por_n & mrst_n;

  guard_wait_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(cnt_rst_n), .load(ld), .load_val(ld_val),
    .cnt(wait_cnt), .idle(wait_idle)
  );

  assign act_ok        = wait_idle;
  assign bank_act_mode = ctrl_q[7];
  assign cfg_err       = bank_act_mode && (pc_code == CODE_W'(1));
  assign trcd_code     = ctrl_q[13:12];
  assign twr_code      = ctrl_q[11:10];
  assign tras_code     = ctrl_q[9:8];
  assign amx_code      = ctrl_q[6:3];
  assign rfsh_en       = ctrl_q[2];
  assign rfsh_mode     = ctrl_q[1];
endmodule

// File: rtl/guard_chk.sv
module guard_chk #(
  parameter int REG_W = 16,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             por_n,
  input logic             mrst_n,
  input logic             wr_en,
  input logic [REG_W-1:0] wr_data,
  input logic             ev_pre,
  input logic             ev_pall_ref,
  input logic             ev_pre_bact,
  input logic             ev_srex,
  input logic             act_ok,
  input logic [REG_W-1:0] ctrl_q,
  input logic             ld,
  input logic [CNT_W-1:0] wait_cnt
);
  assert_write_R2: assert property (@(posedge clk) disable iff (!por_n)
    wr_en |=> ctrl_q == {$past(wr_data[REG_W-1:1]), 1'b0});

  assert_mrst_keeps_R3: assert property (@(posedge clk) disable iff (!por_n)
    (!mrst_n && !wr_en) |=> ctrl_q == $past(ctrl_q));

  assert_pre_blocks_R4: assert property (@(posedge clk) disable iff (!por_n || !mrst_n)
    (ev_pre && !ev_srex && !ev_pall_ref && !ev_pre_bact) |=> !act_ok);

  assert_short_zero_R5: assert property (@(posedge clk) disable iff (!por_n || !mrst_n)
    ((ev_pall_ref || ev_pre_bact) && !ev_srex && ctrl_q[REG_W-1:REG_W-2] == 2'b00 && !wr_en)
      |=> act_ok);

  assert_srex_blocks_R6: assert property (@(posedge clk) disable iff (!por_n || !mrst_n)
    ev_srex |=> !act_ok);

  assert_countdown_R8: assert property (@(posedge clk) disable iff (!por_n || !mrst_n)
    (wait_cnt != '0 && !ld) |=> wait_cnt == $past(wait_cnt) - 1'b1);
endmodule

bind sdram_pre_act_guard guard_chk #(.REG_W(REG_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .por_n(por_n), .mrst_n(mrst_n), .wr_en(wr_en), .wr_data(wr_data),
  .ev_pre(ev_pre), .ev_pall_ref(ev_pall_ref), .ev_pre_bact(ev_pre_bact),
  .ev_srex(ev_srex), .act_ok(act_ok), .ctrl_q(ctrl_q), .ld(ld), .wait_cnt(wait_cnt)
);

// File: tb/tb_sdram_pre_act_guard.sv
module tb_sdram_pre_act_guard;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        por_n = 1'b0, mrst_n = 1'b1, wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        ev_pre = 0, ev_pall_ref = 0, ev_pre_bact = 0, ev_srex = 0;
  logic        act_ok, cfg_err, bank_act_mode, rfsh_en, rfsh_mode;
  logic [15:0] ctrl_q;
  logic [1:0]  trcd_code, twr_code, tras_code;
  logic [3:0]  amx_code;

  int total = 0, bad = 0;
  bit done = 0;

  sdram_pre_act_guard dut (
    .clk(clk), .por_n(por_n), .mrst_n(mrst_n), .wr_en(wr_en), .wr_data(wr_data),
    .ev_pre(ev_pre), .ev_pall_ref(ev_pall_ref), .ev_pre_bact(ev_pre_bact),
    .ev_srex(ev_srex), .act_ok(act_ok), .cfg_err(cfg_err), .ctrl_q(ctrl_q),
    .trcd_code(trcd_code), .twr_code(twr_code), .tras_code(tras_code),
    .bank_act_mode(bank_act_mode), .amx_code(amx_code), .rfsh_en(rfsh_en),
    .rfsh_mode(rfsh_mode)
  );

  // {event[7:6]: 0 ordinary,1 all-bank refresh,2 bank-active,3 self-refresh exit; code[5:4]; wait[3:0]}
  localparam logic [7:0] VEC [15] = '{
    {2'd0, 2'd0, 4'd1}, {2'd0, 2'd1, 4'd2}, {2'd0, 2'd2, 4'd3}, {2'd0, 2'd3, 4'd4},
    {2'd1, 2'd0, 4'd0}, {2'd1, 2'd1, 4'd1}, {2'd1, 2'd2, 4'd2}, {2'd1, 2'd3, 4'd3},
    {2'd2, 2'd0, 4'd0}, {2'd2, 2'd2, 4'd2}, {2'd2, 2'd3, 4'd3},
    {2'd3, 2'd0, 4'd2}, {2'd3, 2'd1, 4'd5}, {2'd3, 2'd2, 4'd8}, {2'd3, 2'd3, 4'd11}
  };

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic set_ev(input logic [3:0] ev); // {srex, bact, pall, pre}
    {ev_srex, ev_pre_bact, ev_pall_ref, ev_pre} = ev;
  endtask

  task automatic count_low(output int n);
    n = 0;
    while (act_ok !== 1'b1 && n < 40) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic pulse(input logic [3:0] ev, output int n);
    @(negedge clk); set_ev(ev);
    @(negedge clk); set_ev(4'b0);
    count_low(n);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    check("R1 ctrl_q in reset", int'(ctrl_q), 0);
    check("R1 act_ok in reset", int'(act_ok), 1);
    por_n = 1'b1;
    @(negedge clk);
    check("R1 cfg_err after reset", int'(cfg_err), 0);

    // Table walk: R4 ordinary, R5 shortened, R6 self-refresh exit
    for (int i = 0; i < 15; i++) begin
      logic [1:0] ev, code;
      int exp;
      ev = VEC[i][7:6]; code = VEC[i][5:4]; exp = int'(VEC[i][3:0]);
      wr({code, 6'b0, (ev == 2'd2), 7'b0});
      pulse(4'b0001 << ev, n);
      case (ev)
        2'd0: check($sformatf("R4 code=%0d", code), n, exp);
        2'd1: check($sformatf("R5 pall code=%0d", code), n, exp);
        2'd2: check($sformatf("R5 bact code=%0d", code), n, exp);
        default: check($sformatf("R6 code=%0d", code), n, exp);
      endcase
    end

    // R2, R10: bit 0 dropped and fields passed out
    wr(16'h9CD7);
    check("R2 readback", int'(ctrl_q), 16'h9CD6);
    check("R10 trcd", int'(trcd_code), 1);
    check("R10 twr", int'(twr_code), 3);
    check("R10 tras", int'(tras_code), 0);
    check("R10 bank_act", int'(bank_act_mode), 1);
    check("R10 amx", int'(amx_code), 10);
    check("R10 rfsh", int'({rfsh_en, rfsh_mode}), 3);
    check("R9 code 10 with bank-active", int'(cfg_err), 0);
    wr(16'h4080);
    check("R9 code 01 with bank-active", int'(cfg_err), 1);
    wr(16'h4000);
    check("R9 code 01 without bank-active", int'(cfg_err), 0);

    // R7 priority with code 10
    wr(16'h8000);
    pulse(4'b1001, n); check("R7 srex over pre", n, 8);
    pulse(4'b0011, n); check("R7 pall over pre", n, 2);
    pulse(4'b1110, n); check("R7 srex over short", n, 8);
    pulse(4'b0101, n); check("R7 bact over pre", n, 2);

    // R8 reload with code 11: ordinary (4) interrupted by self-refresh exit (11)
    wr(16'hC000);
    @(negedge clk); ev_pre = 1'b1;
    @(negedge clk); ev_pre = 1'b0;
    check("R8 wait running", int'(act_ok), 0);
    ev_srex = 1'b1;
    @(negedge clk); ev_srex = 1'b0;
    count_low(n);
    check("R8 reload length", n, 11);

    // R11 write and strobe together use the old code
    wr(16'h0000);
    @(negedge clk); wr_en = 1'b1; wr_data = 16'hC000; ev_pre = 1'b1;
    @(negedge clk); wr_en = 1'b0; ev_pre = 1'b0;
    count_low(n);
    check("R11 old code used", n, 1);
    pulse(4'b0001, n); check("R11 new code next", n, 4);

    // R3 manual reset keeps register, cancels wait
    @(negedge clk); ev_pre = 1'b1;
    @(negedge clk); ev_pre = 1'b0;
    check("R3 wait before mrst", int'(act_ok), 0);
    #2 mrst_n = 1'b0;
    #2 check("R3 act_ok on mrst", int'(act_ok), 1);
    @(negedge clk); mrst_n = 1'b1;
    check("R3 ctrl_q kept", int'(ctrl_q), 16'hC000);

    // R1 power-on reset clears register
    #2 por_n = 1'b0;
    @(negedge clk);
    check("R1 por clears ctrl_q", int'(ctrl_q), 0);
    por_n = 1'b1;
    @(negedge clk);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule